// File: doc/BRIEF.md
# Receive Queue with Character Timeout

This block is the receive data path that sits behind a UART deserializer. Each finished character arrives as a data byte with three error tags (for example parity, framing and break). The block queues these entries and always shows the oldest one to the host, as a holding register with its tags. The tags are separate from the data so that the line-status logic can show the errors of the byte the host is about to take. That logic only ever sees the head entry's errors. An errored byte further back stays hidden until it reaches the head.

With the queue enabled, the block raises a data-ready interrupt once the fill level reaches a selectable trigger. It raises a timeout interrupt when bytes sit below that trigger and nothing happens on the line or the host side for four character times plus twelve bit times. With the queue disabled, the block acts as a single holding register, and every received character requests service.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 16 entries. `fill_o` reports 0 to 16 and `empty_o` is high exactly when the fill is 0. A write adds one entry, a read removes one, and a write and read in the same cycle leave the fill unchanged.
- R2: Entries leave in arrival order. `head_data_o` carries the oldest byte and `head_tags_o` its three tags, in the same bit positions as `wr_tags_i`. Both outputs are zero while the queue is empty.
- R3: After a host read, the next entry's byte and tags appear on the head outputs in the cycle following the read edge.
- R4: A write to a full queue with no read in the same cycle is discarded and sets `overrun_o`. The stored entries and the fill stay unchanged. Any host read clears `overrun_o`.
- R5: With `fifo_on_i` low the capacity is one entry. A second write before a read is an overrun and leaves the first byte at the head.
- R6: A change of `fifo_on_i` empties the queue at the next clock edge and clears `overrun_o`. Writes in that cycle are dropped.
- R7: With the queue enabled, `data_irq_o` is high while the fill is at least the trigger level. `trig_sel_i` codes 0, 1, 2 and 3 select levels 1, 4, 8 and 14. With the queue disabled, `data_irq_o` is high while the holding register is occupied.
- R8: `irq_en_i` low forces both `data_irq_o` and `timeout_irq_o` low.
- R9: In queue mode with data present, `timeout_irq_o` rises on the bit tick that completes 4*(5+`wlen_i`)+12 ticks since the last accepted write or read. Here `wlen_i` 0 to 3 means 5 to 8 data bits. Every accepted write or read restarts the count and drops the timeout.
- R10: The timeout is never active while the queue is empty, and it clears when the last entry is read.
- R11: A read of an empty queue is ignored: the fill stays 0, the head outputs stay zero, and `overrun_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Received character strobe |
| wr_data_i | input | 8 | Received data byte |
| wr_tags_i | input | 3 | Error tags of the received byte |
| rd_en_i | input | 1 | Host read of the holding register |
| fifo_on_i | input | 1 | 1: queue mode, 0: single holding register |
| trig_sel_i | input | 2 | Data-ready trigger level select |
| wlen_i | input | 2 | Data bits per character minus five |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| irq_en_i | input | 1 | Receive interrupt enable |
| head_data_o | output | 8 | Oldest byte (holding register) |
| head_tags_o | output | 3 | Error tags of the oldest byte |
| empty_o | output | 1 | Queue empty |
| fill_o | output | 5 | Number of stored entries |
| overrun_o | output | 1 | A character was lost to a full queue |
| data_irq_o | output | 1 | Data-ready interrupt |
| timeout_irq_o | output | 1 | Character timeout interrupt |

## Verification
The bench fills the queue to its limit and then writes once more. A design that overwrote or advanced on that write would show a new head byte or a fill of 17 instead of keeping the first byte. It counts bit ticks to one short of the timeout limit and then to the limit, for the shortest and longest word lengths. An off-by-one in the limit, or a timer that does not restart on a new write, shows up as an early, late or stuck timeout interrupt. It also checks tags across a pop and a simultaneous read and write, a read of an empty queue, and the single-register mode with its overrun and flush on a mode change. Wrong tags after a pop, a spurious overrun or stale contents across a mode switch would each be reported.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  // Timeout window: CHAR_CNT characters of (MIN_BITS + wlen) bits plus EXTRA_BITS.
  localparam int CHAR_CNT   = 4;
  localparam int MIN_BITS   = 5;
  localparam int EXTRA_BITS = 12;
  localparam int MAX_LIMIT  = CHAR_CNT * (MIN_BITS + 3) + EXTRA_BITS;

  typedef struct packed {
    logic [TAG_W-1:0]  tags;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    trig_level = 1;
      2'd1:    trig_level = 4;
      2'd2:    trig_level = 8;
      default: trig_level = 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  rxq_entry_t       din_i,
  output rxq_entry_t       head_o,
  output logic [CNT_W-1:0] count_o
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rxq_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_ce;

  assign wr_ce = push_i && !flush_i;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push_i) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ce) mem[wptr_q] <= din_i;
  end

  assign head_o  = mem[rptr_q];
  assign count_o = cnt_q;

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R1
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R1
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !flush_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic       restart_i,
  input  logic       tick_i,
  input  logic [1:0] wlen_i,
  output logic       expired_o
);

  localparam int TO_W = $clog2(MAX_LIMIT + 1);

  logic [TO_W-1:0] limit;
  logic [TO_W-1:0] cnt_q, cnt_d;
  logic            exp_q, exp_d;
  logic            cnt_ce;

  always_comb begin
    limit = TO_W'(CHAR_CNT * (MIN_BITS + int'(wlen_i)) + EXTRA_BITS);
  end

  assign cnt_ce = !active_i || restart_i || (tick_i && !exp_q);

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (!active_i || restart_i) begin
      cnt_d = '0;
      exp_d = 1'b0;
    end else if (tick_i && !exp_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q + 1'b1 >= limit) exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;

  // R9
  to_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !exp_q);

  // R9
  to_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !restart_i && !tick_i && !exp_q) |=> !exp_q);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [TAG_W-1:0]  wr_tags_i,
  input  logic              rd_en_i,
  input  logic              fifo_on_i,
  input  logic [1:0]        trig_sel_i,
  input  logic [1:0]        wlen_i,
  input  logic              bit_tick_i,
  input  logic              irq_en_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic [TAG_W-1:0]  head_tags_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic              overrun_o,
  output logic              data_irq_o,
  output logic              timeout_irq_o
);

  rxq_entry_t       wr_entry, head;
  logic [CNT_W-1:0] count, cap;
  logic             mode_q;
  logic             flush, full, push, pop;
  logic             ovr_q, ovr_d;
  logic             tmo;
  int unsigned      trig_eff;

  assign wr_entry = '{tags: wr_tags_i, data: wr_data_i};
  assign flush    = (fifo_on_i != mode_q);
  assign cap      = fifo_on_i ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full     = (count >= cap);
  assign pop      = rd_en_i && (count != '0) && !flush;
  assign push     = wr_en_i && !flush && (!full || pop);

  always_comb begin
    ovr_d = ovr_q;
    if (flush)                 ovr_d = 1'b0;
    else if (wr_en_i && !push) ovr_d = 1'b1;
    else if (rd_en_i)          ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      mode_q <= fifo_on_i;
      ovr_q  <= ovr_d;
    end
  end

  rxq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (flush),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   (wr_entry),
    .head_o  (head),
    .count_o (count)
  );

  rxq_timer i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (fifo_on_i && !flush && (count != '0)),
    .restart_i (push || pop),
    .tick_i    (bit_tick_i),
    .wlen_i    (wlen_i),
    .expired_o (tmo)
  );

  always_comb begin
    trig_eff = fifo_on_i ? trig_level(trig_sel_i) : 1;
  end

  assign empty_o       = (count == '0);
  assign fill_o        = count;
  assign head_data_o   = empty_o ? '0 : head.data;
  assign head_tags_o   = empty_o ? '0 : head.tags;
  assign overrun_o     = ovr_q;
  assign data_irq_o    = irq_en_i && !empty_o && (int'(count) >= trig_eff);
  assign timeout_irq_o = irq_en_i && tmo;

  // R4
  ovr_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && full && !rd_en_i && !flush) |=> (overrun_o && $stable(fill_o)));

  // R6
  mode_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_on_i != mode_q) |=> (empty_o && !overrun_o));

  // R10
  tmo_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq_o |-> !empty_o);

  // R11
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && empty_o && !wr_en_i && !overrun_o) |=> (empty_o && !overrun_o));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> (!data_irq_o && !timeout_irq_o));

endmodule

// File: tb/test_rxq_top.sv
`timescale 1ns/1ps
module test_rxq_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, fifo_on, tick, ien;
  logic [7:0] wr_data;
  logic [2:0] wr_tags;
  logic [1:0] trig_sel, wlen;
  logic [7:0] head_data;
  logic [2:0] head_tags;
  logic       empty, overrun, data_irq, timeout_irq;
  logic [4:0] fill;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  rxq_top i_rxq_top (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .wr_tags_i(wr_tags), .rd_en_i(rd_en), .fifo_on_i(fifo_on),
    .trig_sel_i(trig_sel), .wlen_i(wlen), .bit_tick_i(tick), .irq_en_i(ien),
    .head_data_o(head_data), .head_tags_o(head_tags), .empty_o(empty),
    .fill_o(fill), .overrun_o(overrun), .data_irq_o(data_irq),
    .timeout_irq_o(timeout_irq)
  );

  // Vector: {op[1:0], data[7:0], tags[2:0], exp_head[7:0], exp_tags[2:0], exp_fill[4:0]}
  // op: 0 write, 1 read, 2 read and write together
  localparam int NV = 8;
  localparam logic [28:0] VEC [NV] = '{
    {2'd0, 8'h11, 3'b001, 8'h11, 3'b001, 5'd1},
    {2'd0, 8'h22, 3'b010, 8'h11, 3'b001, 5'd2},
    {2'd0, 8'h33, 3'b100, 8'h11, 3'b001, 5'd3},
    {2'd1, 8'h00, 3'b000, 8'h22, 3'b010, 5'd2},
    {2'd2, 8'h44, 3'b111, 8'h33, 3'b100, 5'd2},
    {2'd1, 8'h00, 3'b000, 8'h44, 3'b111, 5'd1},
    {2'd1, 8'h00, 3'b000, 8'h00, 3'b000, 5'd0},
    {2'd1, 8'h00, 3'b000, 8'h00, 3'b000, 5'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a negedge, take one posedge, return at the next negedge idle.
  task automatic step(input bit w, input logic [7:0] d, input logic [2:0] t, input bit r);
    wr_en = w; wr_data = d; wr_tags = t; rd_en = r;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0; ien = 1'b1;
    fifo_on = 1'b1; trig_sel = 2'd0; wlen = 2'd0; wr_data = '0; wr_tags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);

    // Reset state (R1, R2)
    check("R1 reset fill", fill, 0);
    check("R1 reset empty", empty, 1);
    check("R2 reset head", head_data, 0);
    check("R4 reset overrun", overrun, 0);
    check("R7 reset data irq", data_irq, 0);
    check("R10 reset timeout", timeout_irq, 0);

    // Table walk: order, tags, pop, simultaneous read/write, empty read (R1 R2 R3 R11)
    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      step(e[28:27] != 2'd1, e[26:19], e[18:16], e[28:27] != 2'd0);
      check("R2 head byte", head_data, int'(e[15:8]));
      check("R3 head tags", head_tags, int'(e[7:5]));
      check("R1 fill", fill, int'(e[4:0]));
    end
    check("R11 no overrun on empty read", overrun, 0);
    check("R11 empty after empty read", empty, 1);

    // Trigger level 4 (R7) and enable gating (R8)
    trig_sel = 2'd1;
    for (int i = 0; i < 3; i++) step(1'b1, 8'h40 + 8'(i), 3'(i), 1'b0);
    check("R7 below trigger", data_irq, 0);
    step(1'b1, 8'h43, 3'd3, 1'b0);
    check("R7 at trigger", data_irq, 1);
    ien = 1'b0; #1;
    check("R8 data irq gated", data_irq, 0);
    ien = 1'b1;

    // Fill to 16 then overrun (R1 R4)
    for (int i = 4; i < 16; i++) step(1'b1, 8'h40 + 8'(i), 3'(i), 1'b0);
    check("R1 full fill", fill, 16);
    check("R4 no overrun yet", overrun, 0);
    step(1'b1, 8'hFF, 3'b111, 1'b0);
    check("R4 overrun set", overrun, 1);
    check("R4 fill kept", fill, 16);
    check("R4 head kept", head_data, 8'h40);
    step(1'b0, 8'h00, 3'b000, 1'b1);
    check("R4 overrun cleared by read", overrun, 0);
    check("R3 next head", head_data, 8'h41);
    check("R3 next tags", head_tags, 1);
    check("R1 fill after read", fill, 15);

    // Mode change flushes (R6)
    fifo_on = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6 flushed", fill, 0);
    check("R6 head zero", head_data, 0);

    // Single holding register (R5 R7)
    trig_sel = 2'd3;
    step(1'b1, 8'hAB, 3'b101, 1'b0);
    check("R7 nonfifo irq", data_irq, 1);
    check("R5 holding byte", head_data, 8'hAB);
    check("R5 holding tags", head_tags, 5);
    step(1'b1, 8'hCD, 3'b010, 1'b0);
    check("R5 overrun", overrun, 1);
    check("R5 first kept", head_data, 8'hAB);
    check("R5 fill one", fill, 1);
    step(1'b0, 8'h00, 3'b000, 1'b1);
    check("R5 emptied", fill, 0);

    // Timeout (R9 R10 R8)
    fifo_on = 1'b1; trig_sel = 2'd3; wlen = 2'd0;
    @(posedge clk); @(negedge clk);
    step(1'b1, 8'h5A, 3'b000, 1'b0);
    ticks(31);
    check("R9 no timeout at 31", timeout_irq, 0);
    ticks(1);
    check("R9 timeout at 32", timeout_irq, 1);
    ien = 1'b0; #1;
    check("R8 timeout gated", timeout_irq, 0);
    ien = 1'b1;
    wlen = 2'd3;
    step(1'b1, 8'h5B, 3'b000, 1'b0);
    check("R9 write restarts", timeout_irq, 0);
    ticks(43);
    check("R9 no timeout at 43", timeout_irq, 0);
    ticks(1);
    check("R9 timeout at 44", timeout_irq, 1);
    step(1'b0, 8'h00, 3'b000, 1'b1);
    check("R9 read restarts", timeout_irq, 0);
    ticks(44);
    check("R9 timeout after read", timeout_irq, 1);
    step(1'b0, 8'h00, 3'b000, 1'b1);
    check("R10 cleared when empty", timeout_irq, 0);
    ticks(50);
    check("R10 none while empty", timeout_irq, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule